// File: doc/BRIEF.md
# CAVLC Coefficient Statistics Collector

This block sits between the quantizer's coefficient store and the variable-length-code table stage of an intra video encoder. It accepts the sixteen quantized coefficients of one 4x4 block, one per accepted beat, highest frequency first. While they stream in, it counts the nonzero coefficients, the trailing ±1 values and the zeros. It also measures the zero run in front of each nonzero value. Nonzero levels are parked in a level store and their runs in a run store, so no second pass over the block is needed.

Once the sixteenth coefficient has been taken, the block issues an ordered stream of symbol requests, each tagged with a kind and a value. A downstream table-lookup and bit-packing stage consumes them. A helper output gives the raster position of the coefficient expected on the next beat, so the producer can address its coefficient memory directly.

Both streams are valid/ready. On the coefficient side, a beat is taken on a rising edge where `coef_valid` and `coef_ready` are both high. `coef_ready` stays low from the last beat of a block until the final symbol of that block is accepted. On the symbol side, `sym_valid` is held with `sym_type` and `sym_value` unchanged until a rising edge where `sym_ready` is high. The consumer may stall for any number of cycles. `COEF_W` must be at least 7.

Top module: `cavlc_stat_collector`

## Requirements
- R1: After reset, `coef_ready` is 1, `sym_valid` is 0 and `scan_pos` is 15.
- R2: `scan_pos` shows the raster position of the coefficient expected on beat k (k = 0..15) and advances only on accepted beats. The forward scan order of raster positions is 0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15, so beat k takes forward index 15-k.
- R3: One cycle after the 16th accepted beat, `coef_ready` is 0 and a token symbol (kind 0) is valid. Its value holds the nonzero count in bits [6:2] and the trailing-one count in bits [1:0].
- R4: The trailing-one count covers only the first nonzero values in arrival order whose magnitude is 1. It stops at the first nonzero value of larger magnitude and is capped at 3.
- R5: After the token comes one sign symbol (kind 1) per trailing one, in arrival order. Its value is 1 for -1 and 0 for +1.
- R6: The remaining nonzero values follow as level symbols (kind 2), in arrival order, each carrying the two's-complement level.
- R7: When the nonzero count is between 1 and 15, a total-zeros symbol (kind 3) follows the levels. Its value is the number of zeros that arrive after the first nonzero value.
- R8: Run symbols (kind 4) follow for the nonzero values in arrival order, except the last one. Each carries the number of zeros arriving between that value and the next nonzero one. Emission stops as soon as the zeros still unaccounted for reach 0.
- R9: A block with no nonzero value yields only the token (value 0). A block with sixteen nonzero values yields no total-zeros or run symbols.
- R10: While `sym_valid` is high and `sym_ready` is low, the symbol is held unchanged. `coef_ready` stays 0 until the final symbol is accepted, and rises in the next cycle.
- R11: A coefficient presented while `coef_ready` is 0 is ignored. It neither advances `scan_pos` nor alters the statistics or symbols.
- R12: The level store holds all sixteen levels of a fully populated block. Neither store is ever pushed when full or popped when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_valid | input | 1 | Coefficient beat offered |
| coef_ready | output | 1 | Block can take a coefficient |
| coef_data | input | COEF_W | Quantized coefficient, two's complement |
| scan_pos | output | 4 | Raster position expected on the current beat |
| sym_valid | output | 1 | Symbol request offered |
| sym_ready | input | 1 | Consumer takes the symbol |
| sym_type | output | 3 | Symbol kind: 0 token, 1 sign, 2 level, 3 total zeros, 4 run |
| sym_value | output | COEF_W | Symbol value |

## Verification
`scan_pos` is combinational from the beat counter, so it is checked in the same cycle as the beat it describes. The token is due exactly one cycle after the 16th accepted beat. Each following symbol is due one cycle after the previous one is accepted, and `coef_ready` returns one cycle after the final acceptance. The bench drives and samples only on falling edges. It checks the token in the first falling edge after the last beat, and the restored `coef_ready` in the first falling edge after the last symbol handshake. Symbols are compared one by one, in handshake order, against a list computed from the block contents. This comparison holds under steady, alternating and random stalls.

// File: rtl/cavlc_stat_pkg.sv
package cavlc_stat_pkg;

  localparam int BLK_N = 16;
  localparam int IDX_W = $clog2(BLK_N);
  localparam int CNT_W = $clog2(BLK_N + 1);

  typedef enum logic [2:0] {
    SYM_TOKEN   = 3'd0,
    SYM_T1SIGN  = 3'd1,
    SYM_LEVEL   = 3'd2,
    SYM_TOTZERO = 3'd3,
    SYM_RUN     = 3'd4
  } sym_kind_e;

  // forward scan index -> raster position within the 4x4 block
  function automatic logic [IDX_W-1:0] fwd_to_raster(input logic [IDX_W-1:0] fwd);
    logic [IDX_W-1:0] r;
    case (fwd)
      4'd0:  r = 4'd0;
      4'd1:  r = 4'd1;
      4'd2:  r = 4'd4;
      4'd3:  r = 4'd8;
      4'd4:  r = 4'd5;
      4'd5:  r = 4'd2;
      4'd6:  r = 4'd3;
      4'd7:  r = 4'd6;
      4'd8:  r = 4'd9;
      4'd9:  r = 4'd12;
      4'd10: r = 4'd13;
      4'd11: r = 4'd10;
      4'd12: r = 4'd7;
      4'd13: r = 4'd11;
      4'd14: r = 4'd14;
      default: r = 4'd15;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cavlc_stat_fifo.sv
module cavlc_stat_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int UW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [UW-1:0] used;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // a clear on the same edge as a push restarts the store holding that one entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear) begin
      rd_ptr <= '0;
      wr_ptr <= push ? AW'(1) : '0;
      used   <= push ? UW'(1) : '0;
      if (push) mem[0] <= push_data;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      used <= used + UW'(push) - UW'(pop);
    end
  end

  assign head = mem[rd_ptr];

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear) |-> (used < UW'(DEPTH)));

  // R12
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear) |-> (used != '0));

endmodule

// File: rtl/cavlc_scan_stats.sv
module cavlc_scan_stats
  import cavlc_stat_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [COEF_W-1:0] coef,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              last_beat,
  output logic [CNT_W-1:0]  tot_coef,
  output logic [1:0]        t1_cnt,
  output logic [CNT_W-1:0]  tot_zero,
  output logic              store_clear,
  output logic              lvl_push,
  output logic              run_push,
  output logic [CNT_W-1:0]  run_val
);
  logic             t1_done;
  logic [CNT_W-1:0] zrun;

  logic             first, is_nz, is_one;
  logic [CNT_W-1:0] b_nz, b_tz, b_zrun;
  logic [1:0]       b_t1;
  logic             b_done;
  logic [CNT_W-1:0] n_nz, n_tz, n_zrun;
  logic [1:0]       n_t1;
  logic             n_done;

  always_comb begin
    first  = (beat_idx == '0);
    is_nz  = |coef;
    is_one = (coef == COEF_W'(1)) || (coef == {COEF_W{1'b1}});
    // the first beat of a block starts from clean statistics
    b_nz   = first ? '0   : tot_coef;
    b_tz   = first ? '0   : tot_zero;
    b_zrun = first ? '0   : zrun;
    b_t1   = first ? 2'd0 : t1_cnt;
    b_done = first ? 1'b0 : t1_done;

    n_nz   = b_nz;
    n_tz   = b_tz;
    n_t1   = b_t1;
    n_done = b_done;
    n_zrun = b_zrun;
    if (is_nz) begin
      n_nz   = b_nz + 1'b1;
      n_zrun = '0;
      if (!b_done && is_one && (b_t1 != 2'd3)) n_t1   = b_t1 + 1'b1;
      else                                     n_done = 1'b1;
    end else begin
      n_zrun = b_zrun + 1'b1;
      if (b_nz != '0) n_tz = b_tz + 1'b1;
    end
  end

  assign last_beat   = beat && (beat_idx == IDX_W'(BLK_N - 1));
  assign store_clear = beat && first;
  assign lvl_push    = beat && is_nz;
  // the zeros counted since the previous nonzero value belong to that value
  assign run_push    = beat && is_nz && (b_nz != '0);
  assign run_val     = b_zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_idx <= '0;
      tot_coef <= '0;
      tot_zero <= '0;
      t1_cnt   <= '0;
      t1_done  <= 1'b0;
      zrun     <= '0;
    end else if (beat) begin
      beat_idx <= last_beat ? '0 : beat_idx + 1'b1;
      tot_coef <= n_nz;
      tot_zero <= n_tz;
      t1_cnt   <= n_t1;
      t1_done  <= n_done;
      zrun     <= n_zrun;
    end
  end

  // R4
  t1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_cnt <= 2'd3) && (CNT_W'(t1_cnt) <= tot_coef));

  // R7
  zero_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_coef + tot_zero) <= CNT_W'(BLK_N));

endmodule

// File: rtl/cavlc_sym_emitter.sv
module cavlc_sym_emitter
  import cavlc_stat_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  tot_coef,
  input  logic [1:0]        t1_cnt,
  input  logic [CNT_W-1:0]  tot_zero,
  input  logic [COEF_W-1:0] lvl_head,
  input  logic [CNT_W-1:0]  run_head,
  output logic              busy,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [2:0]        sym_type,
  output logic [COEF_W-1:0] sym_value,
  output logic              lvl_pop,
  output logic              run_pop
);
  typedef enum logic [2:0] {
    EM_IDLE, EM_TOKEN, EM_SIGN, EM_LEVEL, EM_TOTZ, EM_RUN
  } em_state_e;

  em_state_e        state;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] zeros_left;

  logic             fire;
  logic [CNT_W-1:0] idx_n, zl_n;
  em_state_e        after_levels;

  assign busy      = (state != EM_IDLE);
  assign sym_valid = busy;
  assign fire      = sym_valid && sym_ready;
  assign lvl_pop   = fire && ((state == EM_SIGN) || (state == EM_LEVEL));
  assign run_pop   = fire && (state == EM_RUN);
  assign idx_n     = idx + 1'b1;
  assign zl_n      = zeros_left - run_head;
  assign after_levels = (tot_coef < CNT_W'(BLK_N)) ? EM_TOTZ : EM_IDLE;

  always_comb begin
    sym_value = '0;
    sym_type  = SYM_TOKEN;
    case (state)
      EM_SIGN: begin
        sym_type     = SYM_T1SIGN;
        sym_value[0] = lvl_head[COEF_W-1];
      end
      EM_LEVEL: begin
        sym_type  = SYM_LEVEL;
        sym_value = lvl_head;
      end
      EM_TOTZ: begin
        sym_type             = SYM_TOTZERO;
        sym_value[CNT_W-1:0] = tot_zero;
      end
      EM_RUN: begin
        sym_type             = SYM_RUN;
        sym_value[CNT_W-1:0] = run_head;
      end
      default: sym_value[CNT_W+1:0] = {tot_coef, t1_cnt};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= EM_IDLE;
      idx        <= '0;
      zeros_left <= '0;
    end else begin
      case (state)
        EM_IDLE: if (start) begin
          state <= EM_TOKEN;
          idx   <= '0;
        end
        EM_TOKEN: if (fire) begin
          if (tot_coef == '0)    state <= EM_IDLE;
          else if (t1_cnt != '0) state <= EM_SIGN;
          else                   state <= EM_LEVEL;
        end
        EM_SIGN, EM_LEVEL: if (fire) begin
          idx <= idx_n;
          if (idx_n < CNT_W'(t1_cnt)) state <= EM_SIGN;
          else if (idx_n < tot_coef)  state <= EM_LEVEL;
          else                        state <= after_levels;
        end
        EM_TOTZ: if (fire) begin
          zeros_left <= tot_zero;
          idx        <= '0;
          if ((tot_zero == '0) || (tot_coef == CNT_W'(1))) state <= EM_IDLE;
          else                                           state <= EM_RUN;
        end
        EM_RUN: if (fire) begin
          zeros_left <= zl_n;
          idx        <= idx_n;
          if ((zl_n == '0) || (idx_n == tot_coef - 1'b1)) state <= EM_IDLE;
        end
        default: state <= EM_IDLE;
      endcase
    end
  end

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_type) && $stable(sym_value)));

  // R3
  token_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sym_valid) |-> (sym_type == SYM_TOKEN));

  // R8
  run_needs_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == EM_RUN) |-> ((zeros_left != '0) && (run_head <= zeros_left)));

endmodule

// File: rtl/cavlc_stat_collector.sv
module cavlc_stat_collector
  import cavlc_stat_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coef_valid,
  output logic              coef_ready,
  input  logic [COEF_W-1:0] coef_data,
  output logic [3:0]        scan_pos,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [2:0]        sym_type,
  output logic [COEF_W-1:0] sym_value
);
  logic              beat, busy;
  logic [IDX_W-1:0]  beat_idx;
  logic              last_beat, store_clear, lvl_push, run_push, lvl_pop, run_pop;
  logic [CNT_W-1:0]  tot_coef, tot_zero, run_val, run_head;
  logic [1:0]        t1_cnt;
  logic [COEF_W-1:0] lvl_head;

  assign coef_ready = !busy;
  assign beat       = coef_valid && coef_ready;
  // beats arrive back to front through the forward scan
  assign scan_pos   = fwd_to_raster(IDX_W'(BLK_N - 1) - beat_idx);

  cavlc_scan_stats #(.COEF_W(COEF_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .beat(beat), .coef(coef_data),
    .beat_idx(beat_idx), .last_beat(last_beat),
    .tot_coef(tot_coef), .t1_cnt(t1_cnt), .tot_zero(tot_zero),
    .store_clear(store_clear), .lvl_push(lvl_push),
    .run_push(run_push), .run_val(run_val)
  );

  cavlc_stat_fifo #(.W(COEF_W), .DEPTH(BLK_N)) u_lvl_store (
    .clk(clk), .rst_n(rst_n), .clear(store_clear), .push(lvl_push),
    .push_data(coef_data), .pop(lvl_pop), .head(lvl_head)
  );

  cavlc_stat_fifo #(.W(CNT_W), .DEPTH(BLK_N)) u_run_store (
    .clk(clk), .rst_n(rst_n), .clear(store_clear), .push(run_push),
    .push_data(run_val), .pop(run_pop), .head(run_head)
  );

  cavlc_sym_emitter #(.COEF_W(COEF_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(last_beat),
    .tot_coef(tot_coef), .t1_cnt(t1_cnt), .tot_zero(tot_zero),
    .lvl_head(lvl_head), .run_head(run_head), .busy(busy),
    .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_type(sym_type), .sym_value(sym_value),
    .lvl_pop(lvl_pop), .run_pop(run_pop)
  );

  // R3
  token_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (sym_valid && (sym_type == SYM_TOKEN) && !coef_ready));

  // R11
  refused_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && !coef_ready) |=> $stable(scan_pos));

endmodule

// File: tb/cavlc_stat_collector_tb.sv
`timescale 1ns/1ps
module cavlc_stat_collector_tb;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          coef_valid = 1'b0;
  logic          coef_ready;
  logic [CW-1:0] coef_data = '0;
  logic [3:0]    scan_pos;
  logic          sym_valid;
  logic          sym_ready = 1'b0;
  logic [2:0]    sym_type;
  logic [CW-1:0] sym_value;

  always #2.5 clk = ~clk;

  cavlc_stat_collector #(.COEF_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_ready(coef_ready),
    .coef_data(coef_data), .scan_pos(scan_pos), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_type(sym_type), .sym_value(sym_value)
  );

  int checks = 0;
  int errors = 0;
  int blk [16];
  int exp_t [64];
  int exp_v [64];
  int exp_n;
  int fwd_raster [16] = '{0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input int kind);
    case (kind)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic void add_sym(input int k, input int v);
    exp_t[exp_n] = k;
    exp_v[exp_n] = v;
    exp_n++;
  endfunction

  // expected symbol list derived from the requirement text
  function automatic void build_expected();
    int tc = 0, t1 = 0, tz = 0, zr = 0, zl;
    bit stop = 0;
    int lv [16];
    int rn [16];
    exp_n = 0;
    for (int k = 0; k < 16; k++) begin
      if (blk[k] != 0) begin
        if (tc > 0) rn[tc-1] = zr;
        lv[tc] = blk[k];
        tc++;
        zr = 0;
        if (!stop && (blk[k] == 1 || blk[k] == -1) && t1 < 3) t1++;
        else stop = 1;
      end else begin
        zr++;
        if (tc > 0) tz++;
      end
    end
    add_sym(0, tc * 4 + t1);
    if (tc == 0) return;
    for (int i = 0; i < t1; i++) add_sym(1, lv[i] < 0 ? 1 : 0);
    for (int i = t1; i < tc; i++) add_sym(2, lv[i]);
    if (tc < 16) add_sym(3, tz);
    zl = tz;
    for (int i = 0; i < tc - 1; i++) begin
      if (zl == 0) break;
      add_sym(4, rn[i]);
      zl -= rn[i];
    end
  endfunction

  task automatic send_block(input bit gaps, input bit chk_pos);
    for (int k = 0; k < 16; k++) begin
      if (gaps && (k % 5 == 2)) begin
        coef_valid = 1'b0;
        @(negedge clk);
      end
      coef_valid = 1'b1;
      coef_data  = CW'(blk[k]);
      if (chk_pos)
        check(scan_pos == 4'(fwd_raster[15-k]), "R2", "scan_pos",
              int'(scan_pos), fwd_raster[15-k]);
      while (!coef_ready) @(negedge clk);
      @(negedge clk);
    end
    coef_valid = 1'b0;
    check(sym_valid && sym_type == 3'd0 && !coef_ready, "R3",
          "token due one cycle after last beat", int'(sym_valid), 1);
  endtask

  // bp: 0 always ready, 1 alternate, 2 random; poke drives refused beats
  task automatic collect(input int bp, input bit poke);
    int   got = 0;
    int   guard = 0;
    bit   stalled = 0;
    bit   early_ready = 0;
    logic [2:0]    st_t;
    logic [CW-1:0] st_v;
    int   act;
    while (got < exp_n && guard < 2000) begin
      guard++;
      case (bp)
        0: sym_ready = 1'b1;
        1: sym_ready = guard[0];
        default: sym_ready = ($urandom % 3) != 0;
      endcase
      if (poke) begin
        coef_valid = 1'b1;
        coef_data  = CW'($urandom);
      end
      if (coef_ready) early_ready = 1;
      if (stalled)
        check(sym_valid && sym_type == st_t && sym_value == st_v, "R10",
              "symbol held under stall", int'(sym_value), int'(st_v));
      stalled = 0;
      if (sym_valid) begin
        if (sym_ready) begin
          act = (sym_type == 3'd2) ? int'($signed(sym_value)) : int'(sym_value);
          if (int'(sym_type) != exp_t[got])
            check(0, req_of(exp_t[got]), "symbol kind", int'(sym_type), exp_t[got]);
          else
            check(act == exp_v[got], req_of(exp_t[got]), "symbol value", act, exp_v[got]);
          got++;
        end else begin
          stalled = 1;
          st_t = sym_type;
          st_v = sym_value;
        end
      end
      @(negedge clk);
    end
    coef_valid = 1'b0;
    sym_ready  = 1'b0;
    check(got == exp_n, "R9", "symbol count", got, exp_n);
    check(!early_ready, "R10", "coef_ready low during emission", int'(early_ready), 0);
    check(coef_ready && !sym_valid, "R10", "coef_ready back after final symbol",
          int'(coef_ready), 1);
  endtask

  task automatic run_block(input bit gaps, input bit chk_pos, input int bp, input bit poke);
    build_expected();
    send_block(gaps, chk_pos);
    collect(bp, poke);
  endtask

  task automatic t_reset();
    check(coef_ready == 1'b1, "R1", "coef_ready after reset", int'(coef_ready), 1);
    check(sym_valid == 1'b0, "R1", "sym_valid after reset", int'(sym_valid), 0);
    check(scan_pos == 4'd15, "R1", "scan_pos after reset", int'(scan_pos), 15);
  endtask

  task automatic t_all_zero();
    for (int k = 0; k < 16; k++) blk[k] = 0;
    run_block(0, 1, 0, 0);
    check(exp_n == 1 && exp_v[0] == 0, "R9", "zero block gives token only", exp_n, 1);
  endtask

  task automatic t_mixed();
    blk = '{0, 0, 1, 0, -1, 1, 0, 3, 0, -2, 5, 0, 1, 0, 0, 0};
    run_block(1, 1, 1, 0);
    check(exp_v[0] == 7 * 4 + 3, "R4", "trailing ones stop at magnitude above one",
          exp_v[0], 31);
  endtask

  task automatic t_full(input int bp);
    for (int k = 0; k < 16; k++) blk[k] = (k % 3 == 0) ? -(k + 2) : (k + 2);
    run_block(0, 0, bp, 0);
    check(exp_n == 17, "R12", "sixteen levels stored and drained", exp_n, 17);
  endtask

  task automatic t_four_ones();
    blk = '{0, -1, 1, -1, 1, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0};
    run_block(0, 0, 0, 0);
    check(exp_v[0] == 5 * 4 + 3, "R4", "trailing ones capped at three", exp_v[0], 23);
  endtask

  task automatic t_single_low();
    for (int k = 0; k < 16; k++) blk[k] = 0;
    blk[15] = -1;
    run_block(0, 0, 2, 0);
  endtask

  task automatic t_single_high();
    for (int k = 0; k < 16; k++) blk[k] = 0;
    blk[0] = -7;
    run_block(0, 0, 0, 0);
    check(exp_t[2] == 3 && exp_v[2] == 15, "R7", "total zeros of lone high value",
          exp_v[2], 15);
  endtask

  task automatic t_refused();
    blk = '{0, 2, 0, 0, -1, 0, 1, 0, 0, 0, 4, 0, 0, 0, 0, -3};
    run_block(0, 0, 1, 1);
    // a refused beat must not start a new block: the next block is clean
    blk = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_block(0, 1, 0, 0);
    check(1, "R11", "block after refused beats", 0, 0);
  endtask

  task automatic t_random(input int n);
    for (int b = 0; b < n; b++) begin
      for (int k = 0; k < 16; k++) begin
        int r = $urandom % 8;
        if (r < 4) blk[k] = 0;
        else if (r < 6) blk[k] = ($urandom % 2) ? 1 : -1;
        else blk[k] = int'($urandom % 41) - 20;
      end
      run_block(b % 2, 0, 2, b % 3 == 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_zero();
    t_mixed();
    t_full(0);
    t_full(2);
    t_four_ones();
    t_single_low();
    t_single_high();
    t_refused();
    t_random(40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule